// File: doc/BRIEF.md
# Majority-Vote Asynchronous Serial Receiver

This block receives asynchronous serial frames and turns them into bytes (or 9-bit words) held in a two-entry receive queue. It runs from the system clock and is paced by a one-cycle oversample strobe that pulses sixteen times per bit period. In the idle state it watches for a falling edge on the line. From that edge it counts strobes through each bit and takes three samples near the middle of every bit. The value of the bit is the majority of those three samples. There are two sample patterns. A fast pattern spreads the samples over the bit (strobes 4, 8 and 12). A slow pattern bunches them around the centre (strobes 7, 8 and 9).

A completed frame goes into the queue together with its framing-error mark and its ninth bit. The host reads entries in arrival order with a read strobe. An interrupt level stays high while anything is queued. When a frame completes while both entries are full, the receiver raises a sticky overrun flag, drops the frame and stops receiving. The host recovers by dropping the continuous-receive enable. Dropping the port enable aborts everything and empties the queue. The serial input is expected to be synchronous to `clk`.

Top module: `uart_mv_rx`

## Requirements
- R1: After reset, with the port disabled, `rx_idle` is 1 and `rx_irq` and `overrun` are 0.
- R2: While waiting, a 1-to-0 change of the (polarity-corrected) line seen on a strobe starts a frame, and that strobe is tick 0 of the start bit. If the majority of the start-bit samples is 1, the start is rejected, nothing is queued and the receiver waits again.
- R3: Counting the edge strobe as tick 0 of the start bit, each bit lasts 16 strobes. The bit is the majority of the line at ticks 4, 8 and 12 of that bit when `hi_speed`=1, and at ticks 7, 8 and 9 when `hi_speed`=0. Line values at other ticks have no effect.
- R4: A frame is one start bit (0), eight data bits sent LSB first, then a ninth bit only when `nine_bit_en`=1, then a stop bit. `rd_data` shows the data and `rd_bit9` shows the ninth bit, which is 0 in 8-bit mode.
- R5: A stop bit voted 0 stores `frame_err`=1 with that entry, and the frame is still queued.
- R6: The queue holds two entries. The head (`rd_data`, `rd_bit9`, `frame_err`) is the oldest entry, and a `rd_en` pulse removes it.
- R7: `rx_irq` is 1 exactly while the queue holds at least one entry, and it falls when the last entry is read.
- R8: A frame that completes while the queue is full sets `overrun`. The frame is discarded and no further frame is received. Setting `cont_en`=0 clears `overrun` on the next clock.
- R9: With `port_en`=0 the receiver is disabled, an ongoing frame is abandoned and the queue is emptied on the next clock.
- R10: `rx_idle` is 1 while disabled or waiting for a start edge, and 0 from the strobe after an accepted edge until the stop bit is voted.
- R11: With `rx_invert`=1 the line is inverted before edge detection and sampling, so an inverted frame is received as the same data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Serial input, synchronous to clk |
| os_tick | input | 1 | One-cycle strobe, 16 per bit period |
| port_en | input | 1 | Serial port enable; 0 disables and flushes |
| cont_en | input | 1 | Continuous receive enable; 0 clears overrun |
| nine_bit_en | input | 1 | Frame carries a ninth bit |
| hi_speed | input | 1 | 1: samples at ticks 4/8/12, 0: at 7/8/9 |
| rx_invert | input | 1 | Invert line polarity before sampling |
| rd_en | input | 1 | Pop the oldest queue entry |
| rd_data | output | 8 | Data of the oldest entry |
| rd_bit9 | output | 1 | Ninth bit of the oldest entry |
| frame_err | output | 1 | Framing error of the oldest entry |
| overrun | output | 1 | Sticky overrun flag |
| rx_irq | output | 1 | Queue not empty |
| rx_idle | output | 1 | Receiver disabled or waiting for start |

## Verification
Clean frames in both speed modes show that LSB-first assembly and the ninth bit are correct. Glitches placed on ticks between the sample points, or on one sample point only, must leave the data unchanged. Glitches on two sample points of the active pattern must flip every bit, and that result tells the fast sample positions apart from the slow ones. Directed runs check a start rejected by its samples, a bad stop bit, two queued frames read in order, a third frame that overruns, a frame sent after overrun that is ignored, a flush by disabling the port, and an inverted line. Random frames with random glitches on the data and stop bits, in every mode combination, are compared against a model in the bench that votes on the exact waveform driven.

// File: rtl/mvrx_pkg.sv
package mvrx_pkg;
  localparam int OS_TICKS = 16;
  localparam int TCNT_W   = $clog2(OS_TICKS);

  typedef enum logic [2:0] {
    ST_OFF, ST_WAIT, ST_MAYBE, ST_MID1, ST_MID2, ST_MID3, ST_RECV
  } rx_state_t;

  // Tick index (within a bit) of sample k (0..2) for the chosen speed mode.
  function automatic logic [TCNT_W-1:0] samp_pos(input logic hi, input int k);
    int p;
    if (hi) p = (OS_TICKS / 4) * (k + 1);
    else    p = (OS_TICKS / 2) - 1 + k;
    return TCNT_W'(p);
  endfunction

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/mvrx_sampler.sv
module mvrx_sampler
  import mvrx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic line,
  input  logic hi_speed,
  input  logic run,
  input  logic restart,
  output logic samp_stb,
  output logic vote_stb,
  output logic vote_val,
  output logic bit_end
);
  logic [TCNT_W-1:0] tcnt, tnext;
  logic [TCNT_W-1:0] p0, p1, p2;
  logic s_a, s_b;
  logic at_p0, at_p1, at_p2;

  assign p0    = samp_pos(hi_speed, 0);
  assign p1    = samp_pos(hi_speed, 1);
  assign p2    = samp_pos(hi_speed, 2);
  assign tnext = tcnt + 1'b1;
  assign at_p0 = (tnext == p0);
  assign at_p1 = (tnext == p1);
  assign at_p2 = (tnext == p2);

  assign samp_stb = run && tick && (at_p0 || at_p1 || at_p2);
  assign vote_stb = run && tick && at_p2;
  assign vote_val = maj3(s_a, s_b, line);
  assign bit_end  = run && tick && (tcnt == TCNT_W'(OS_TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt <= '0;
      s_a  <= 1'b0;
      s_b  <= 1'b0;
    end else if (restart) begin
      tcnt <= '0;
    end else if (run && tick) begin
      tcnt <= tnext;
      if (at_p0) s_a <= line;
      if (at_p1) s_b <= line;
    end
  end

  // R3: no sample point falls on the last tick of a bit
  assert_no_edge_sample_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_end |-> !samp_stb);
endmodule

// File: rtl/mvrx_fifo.sv
module mvrx_fifo #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] head,
  output logic [1:0]   cnt
);
  logic [W-1:0] slot0, slot1;
  logic pop_eff;

  assign pop_eff = pop && (cnt != 2'd0);
  assign head    = slot0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot0 <= '0;
      slot1 <= '0;
      cnt   <= 2'd0;
    end else if (flush) begin
      cnt <= 2'd0;
    end else begin
      case ({push, pop_eff})
        2'b11: begin
          if (cnt == 2'd1) slot0 <= din;
          else begin
            slot0 <= slot1;
            slot1 <= din;
          end
        end
        2'b10: begin
          if (cnt == 2'd0) slot0 <= din;
          else             slot1 <= din;
          cnt <= cnt + 2'd1;
        end
        2'b01: begin
          slot0 <= slot1;
          cnt   <= cnt - 2'd1;
        end
        default: ;
      endcase
    end
  end

  // R6: the writer never pushes into a full queue without a pop
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop_eff && !flush) |-> (cnt < 2'd2));
endmodule

// File: rtl/uart_mv_rx.sv
module uart_mv_rx
  import mvrx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_line,
  input  logic              os_tick,
  input  logic              port_en,
  input  logic              cont_en,
  input  logic              nine_bit_en,
  input  logic              hi_speed,
  input  logic              rx_invert,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_bit9,
  output logic              frame_err,
  output logic              overrun,
  output logic              rx_irq,
  output logic              rx_idle
);
  localparam int BIT_W   = $clog2(DATA_W + 3);
  localparam int ENTRY_W = DATA_W + 2;

  rx_state_t state;
  logic [BIT_W-1:0]  bitn, stop_idx;
  logic [DATA_W-1:0] dat;
  logic              b9, prev_line, ovr;
  logic              line_s, rx_ok, run;
  logic              edge_det, start_reject, frame_done, ovr_hit, push;
  logic              samp_stb, vote_stb, vote_val, bit_end;
  logic [ENTRY_W-1:0] din, head;
  logic [1:0]        fcnt;

  assign line_s   = rx_line ^ rx_invert;
  assign rx_ok    = port_en && cont_en && !ovr;
  assign run      = (state != ST_OFF) && (state != ST_WAIT);
  assign stop_idx = nine_bit_en ? BIT_W'(DATA_W + 2) : BIT_W'(DATA_W + 1);

  assign edge_det     = rx_ok && (state == ST_WAIT) && os_tick && prev_line && !line_s;
  assign start_reject = rx_ok && (state == ST_MID3) && vote_stb && (bitn == '0) && vote_val;
  assign frame_done   = rx_ok && (state == ST_MID3) && vote_stb && (bitn == stop_idx);
  assign ovr_hit      = frame_done && (fcnt == 2'd2) && !rd_en;
  assign push         = frame_done && !ovr_hit;
  assign din          = {~vote_val, b9, dat};

  mvrx_sampler u_samp (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (os_tick),
    .line     (line_s),
    .hi_speed (hi_speed),
    .run      (run),
    .restart  (edge_det),
    .samp_stb (samp_stb),
    .vote_stb (vote_stb),
    .vote_val (vote_val),
    .bit_end  (bit_end)
  );

  mvrx_fifo #(.W(ENTRY_W)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (!port_en),
    .push  (push),
    .pop   (rd_en),
    .din   (din),
    .head  (head),
    .cnt   (fcnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_OFF;
      bitn      <= '0;
      dat       <= '0;
      b9        <= 1'b0;
      prev_line <= 1'b0;
      ovr       <= 1'b0;
    end else begin
      if (os_tick) prev_line <= line_s;

      if (!port_en || !cont_en) ovr <= 1'b0;
      else if (ovr_hit)         ovr <= 1'b1;

      if (!port_en) begin
        state <= ST_OFF;
      end else if (!cont_en || ovr) begin
        state <= ST_WAIT;
      end else begin
        case (state)
          ST_OFF:  state <= ST_WAIT;
          ST_WAIT: if (edge_det) begin
            state <= ST_MAYBE;
            bitn  <= '0;
            b9    <= 1'b0;
          end
          ST_MAYBE, ST_MID1: if (samp_stb) state <= ST_MID2;
          ST_MID2: if (samp_stb) state <= ST_MID3;
          ST_MID3: if (vote_stb) begin
            if (bitn == '0) begin
              state <= vote_val ? ST_WAIT : ST_RECV;
            end else if (bitn == stop_idx) begin
              state <= ST_WAIT;
            end else begin
              if (bitn <= BIT_W'(DATA_W)) dat <= {vote_val, dat[DATA_W-1:1]};
              else                        b9  <= vote_val;
              state <= ST_RECV;
            end
          end
          ST_RECV: if (bit_end) begin
            bitn  <= bitn + 1'b1;
            state <= ST_MID1;
          end
          default: state <= ST_WAIT;
        endcase
      end
    end
  end

  assign rx_irq    = (fcnt != 2'd0);
  assign rd_data   = head[DATA_W-1:0];
  assign rd_bit9   = head[DATA_W] && rx_irq;
  assign frame_err = head[DATA_W+1] && rx_irq;
  assign overrun   = ovr;
  assign rx_idle   = (state == ST_OFF) || (state == ST_WAIT);

  // R2: a rejected start returns the receiver to idle
  assert_reject_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_reject |=> rx_idle);
  // R10: an accepted edge makes the receiver busy
  assert_start_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    edge_det |=> !rx_idle);
  // R5: a bad stop into an empty queue shows up at the head
  assert_ferr_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !vote_val && !rx_irq) |=> (frame_err && rx_irq));
  // R7: the interrupt only falls through a read or a disable
  assert_irq_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_irq) |-> ($past(rd_en) || !$past(port_en)));
  // R8: overrun is sticky while both enables stay high
  assert_ovr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && port_en && cont_en) |=> overrun);
  // R9: disabling flushes and idles
  assert_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> (!rx_irq && rx_idle));
endmodule

// File: tb/sim_uart_mv_rx.sv
`timescale 1ns/1ps
module sim_uart_mv_rx;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, rx_line, os_tick, port_en, cont_en, nine_bit_en, hi_speed, rx_invert, rd_en;
  logic [7:0] rd_data;
  logic rd_bit9, frame_err, overrun, rx_irq, rx_idle;

  uart_mv_rx u0 (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .os_tick(os_tick),
    .port_en(port_en), .cont_en(cont_en), .nine_bit_en(nine_bit_en),
    .hi_speed(hi_speed), .rx_invert(rx_invert), .rd_en(rd_en),
    .rd_data(rd_data), .rd_bit9(rd_bit9), .frame_err(frame_err),
    .overrun(overrun), .rx_irq(rx_irq), .rx_idle(rx_idle)
  );

  int n_cmp = 0, n_bad = 0;
  bit cfg_hi, cfg_nine, cfg_inv;
  bit men, mov;
  logic [9:0] mq [2];
  int mcnt;

  function automatic bit bmaj(bit a, bit b, bit c);
    return (int'(a) + int'(b) + int'(c)) >= 2;
  endfunction

  function automatic int bpos(bit hi, int k);
    return hi ? 4 + 4 * k : 7 + k;
  endfunction

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic tick(input bit v);
    @(negedge clk);
    hi_speed = cfg_hi; nine_bit_en = cfg_nine; rx_invert = cfg_inv;
    rx_line = v ^ cfg_inv;
    os_tick = 1'b1;
    @(negedge clk);
    os_tick = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) tick(1'b1);
  endtask

  task automatic send_frame(input logic [8:0] d, input bit reject,
                            input logic [15:0] gmask, input bit rnd, input bit stop_bad);
    bit wv [16];
    bit votes [11];
    int nb;
    bit bv, accepting;
    accepting = men && !mov;
    nb = cfg_nine ? 11 : 10;
    for (int b = 0; b < nb; b++) begin
      if (b == 0)           bv = 1'b0;
      else if (b == nb - 1) bv = !stop_bad;
      else if (b <= 8)      bv = d[b-1];
      else                  bv = d[8];
      for (int t = 0; t < 16; t++) begin
        bit v;
        v = bv;
        if (b == 0 && reject && t >= 2) v = 1'b1;
        if (b > 0 && b < nb - 1) v = v ^ gmask[t];
        if (rnd && b > 0 && (b < nb - 1 || t <= bpos(cfg_hi, 2)) && ($urandom % 6 == 0)) v = ~v;
        wv[t] = v;
        if (b == 3 && t == 1 && accepting && !reject)
          chk("R10 busy during frame", 32'(rx_idle), 32'd0);
        tick(v);
      end
      votes[b] = bmaj(wv[bpos(cfg_hi, 0)], wv[bpos(cfg_hi, 1)], wv[bpos(cfg_hi, 2)]);
      if (b == 0 && reject) break;
    end
    idle(4);
    if (accepting && !reject) begin
      logic [9:0] e;
      for (int i = 0; i < 8; i++) e[i] = votes[i + 1];
      e[8] = cfg_nine ? votes[9] : 1'b0;
      e[9] = !votes[nb - 1];
      if (mcnt == 2) mov = 1'b1;
      else begin
        mq[mcnt] = e;
        mcnt++;
      end
    end
  endtask

  task automatic read_check(input string tag);
    logic [9:0] e;
    e = mq[0];
    chk({tag, " irq before read"}, 32'(rx_irq), 32'd1);
    chk({tag, " data"}, 32'(rd_data), 32'(e[7:0]));
    chk({tag, " ninth bit"}, 32'(rd_bit9), 32'(e[8]));
    chk({tag, " framing"}, 32'(frame_err), 32'(e[9]));
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    mq[0] = mq[1];
    mcnt--;
  endtask

  task automatic drain(input string tag);
    while (mcnt > 0) read_check(tag);
    chk({tag, " R7 irq after last read"}, 32'(rx_irq), 32'd0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired, run hung");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; rx_line = 1'b1; os_tick = 1'b0; port_en = 1'b0; cont_en = 1'b0;
    nine_bit_en = 1'b0; hi_speed = 1'b1; rx_invert = 1'b0; rd_en = 1'b0;
    cfg_hi = 1; cfg_nine = 0; cfg_inv = 0; men = 0; mov = 0; mcnt = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", 32'(rx_idle), 32'd1);
    chk("R1 irq after reset", 32'(rx_irq), 32'd0);
    chk("R1 overrun after reset", 32'(overrun), 32'd0);

    port_en = 1'b1; cont_en = 1'b1; men = 1;
    idle(3);
    chk("R10 idle while waiting", 32'(rx_idle), 32'd1);

    // Clean frames, fast pattern
    send_frame(9'h0A5, 0, 16'h0, 0, 0);
    chk("R4 LSB-first data", 32'(rd_data), 32'hA5);
    drain("R4 clean fast");
    // Glitches between fast sample points: no effect
    send_frame(9'h03C, 0, 16'h00E0, 0, 0);
    chk("R3 off-sample glitch ignored", 32'(rd_data), 32'h3C);
    drain("R3 fast off-sample");
    // One sample point glitched: majority holds
    send_frame(9'h03C, 0, 16'h0010, 0, 0);
    chk("R3 single sample outvoted", 32'(rd_data), 32'h3C);
    drain("R3 fast single");
    // Two fast sample points glitched: bits flip
    send_frame(9'h03C, 0, 16'h0110, 0, 0);
    chk("R3 two fast samples flip", 32'(rd_data), 32'hC3);
    drain("R3 fast double");

    // Slow pattern: fast positions have no effect, slow ones do
    cfg_hi = 0; idle(2);
    send_frame(9'h05E, 0, 16'h1010, 0, 0);
    chk("R3 slow ignores ticks 4 and 12", 32'(rd_data), 32'h5E);
    drain("R3 slow off-sample");
    send_frame(9'h05E, 0, 16'h0180, 0, 0);
    chk("R3 slow ticks 7 and 8 flip", 32'(rd_data), 32'hA1);
    drain("R3 slow double");

    // Ninth bit
    cfg_nine = 1; cfg_hi = 1; idle(2);
    send_frame(9'h15A, 0, 16'h0, 0, 0);
    chk("R4 ninth bit set", 32'(rd_bit9), 32'd1);
    drain("R4 nine-bit one");
    send_frame(9'h0FF, 0, 16'h0, 0, 0);
    drain("R4 nine-bit zero");
    cfg_nine = 0; idle(2);

    // Framing error still queued
    send_frame(9'h077, 0, 16'h0, 0, 1);
    chk("R5 bad stop flagged", 32'(frame_err), 32'd1);
    chk("R5 bad stop data kept", 32'(rd_data), 32'h77);
    drain("R5 framing");

    // Start rejected by its samples
    send_frame(9'h000, 1, 16'h0, 0, 0);
    chk("R2 rejected start queues nothing", 32'(rx_irq), 32'd0);
    chk("R2 idle after reject", 32'(rx_idle), 32'd1);
    send_frame(9'h09C, 0, 16'h0, 0, 0);
    drain("R2 frame after reject");

    // Two-entry ordering
    send_frame(9'h011, 0, 16'h0, 0, 0);
    send_frame(9'h022, 0, 16'h0, 0, 0);
    chk("R6 head is oldest", 32'(rd_data), 32'h11);
    drain("R6 order");

    // Overrun
    send_frame(9'h031, 0, 16'h0, 0, 0);
    send_frame(9'h032, 0, 16'h0, 0, 0);
    chk("R8 no overrun at two", 32'(overrun), 32'd0);
    send_frame(9'h033, 0, 16'h0, 0, 0);
    chk("R8 overrun set", 32'(overrun), 32'd1);
    send_frame(9'h034, 0, 16'h0, 0, 0);
    drain("R8 kept entries");
    chk("R8 overrun sticky", 32'(overrun), 32'd1);
    send_frame(9'h035, 0, 16'h0, 0, 0);
    chk("R8 reception stopped", 32'(rx_irq), 32'd0);
    @(negedge clk); cont_en = 1'b0;
    @(negedge clk);
    chk("R8 overrun cleared", 32'(overrun), 32'd0);
    mov = 0; cont_en = 1'b1;
    idle(2);
    send_frame(9'h036, 0, 16'h0, 0, 0);
    drain("R8 resumed");

    // Disable flushes
    send_frame(9'h044, 0, 16'h0, 0, 0);
    chk("R9 queued before disable", 32'(rx_irq), 32'd1);
    @(negedge clk); port_en = 1'b0; men = 0;
    @(negedge clk);
    chk("R9 flushed", 32'(rx_irq), 32'd0);
    chk("R9 idle when disabled", 32'(rx_idle), 32'd1);
    mcnt = 0;
    port_en = 1'b1; men = 1;
    idle(3);

    // Inverted line
    cfg_inv = 1; idle(2);
    send_frame(9'h06B, 0, 16'h0, 0, 0);
    chk("R11 inverted data", 32'(rd_data), 32'h6B);
    drain("R11 invert");

    // Random frames with random glitches
    for (int i = 0; i < 40; i++) begin
      cfg_hi = bit'($urandom % 2);
      cfg_nine = bit'($urandom % 2);
      cfg_inv = bit'($urandom % 2);
      idle(2);
      send_frame(9'($urandom), 0, 16'h0, 1, 0);
      drain("R3 random");
    end

    summary();
    $finish;
  end
endmodule